// File: doc/BRIEF.md
# NOR Flash Operation Completion Poller

This block sits on the host side of a parallel NOR flash interface. It decides when an embedded program or erase operation has finished. Software or a sequencer issues the command sequence elsewhere. It then pulses `start` with the target address and the byte that was written. From that point the block repeatedly reads the target address through a read request channel and interprets the status bits that a busy flash drives onto the data bus instead of array contents.

Two decision methods are available, and `toggle_mode` picks one when a run is accepted. Data polling compares bit 7 of each read with bit 7 of the expected byte. Toggle checking compares bit 2 of consecutive reads. In both methods, bit 5 set on a read that still shows "busy" triggers exactly one confirming read, which then settles the run as a pass or a failure. A programmable limit on the number of polls turns a run that never finishes into a timeout. Every run ends with a single-cycle `done` pulse and a 2-bit result code. A failure or timeout also leaves a sticky error flag.

The read request channel is valid/ready. `rd_valid` stays high with a constant `rd_addr` until `rd_ready` is seen high on a clock edge, so the bus side can stall for any number of cycles. Only one read is ever outstanding. The block is always ready for the response, and `rsp_valid` is a one-cycle strobe that carries `rsp_data`.

Top module: `nor_done_poller`

## Requirements
- R1: After reset, `busy`, `done`, `rd_valid` and `err_flag` are all low.
- R2: A `start` accepted while idle latches `start_addr`, and every read request of the run carries that address. `rd_valid` stays high with a stable `rd_addr` until the cycle in which `rd_ready` is high, and it is never high while idle.
- R3: In data-poll mode (`toggle_mode`=0), a response whose bit 7 equals bit 7 of the expected byte ends the run with result 00 (pass).
- R4: In data-poll mode, a response whose bit 7 differs and whose bit 5 is 0 leads to another read of the same address.
- R5: In data-poll mode, a response whose bit 7 differs and whose bit 5 is 1 leads to exactly one more read. If that read's bit 7 matches the expected bit 7, the result is 00; otherwise it is 01 (fail).
- R6: In toggle mode (`toggle_mode`=1), the first read of a run only records its bit 2. Each later read compares its bit 2 with the previous read's bit 2, and equal values end the run with result 00.
- R7: In toggle mode, a differing bit 2 with bit 5 at 0 leads to another read. A differing bit 2 with bit 5 at 1 leads to exactly one more read, which passes (00) if its bit 2 equals that of the read that showed bit 5, and fails (01) otherwise.
- R8: Each read except a confirming read counts as one poll. When a read calls for further polling and the run has already made `poll_limit` polls, the run ends with result 10 (timeout). A limit of 0 behaves as 1.
- R9: `done` is high for exactly one cycle per run, `busy` is low in that cycle, and `result` is never 11.
- R10: `err_flag` rises together with a `done` that carries result 01 or 10, and stays high until the next accepted `start` clears it. A pass leaves it low.
- R11: A `start` that arrives while a run is busy is ignored: the run continues at its original address with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| start_addr | input | ADDR_W | Address inside the location being programmed or erased |
| start_data | input | DQ_W | Byte that was written (bit 7 used in data-poll mode) |
| toggle_mode | input | 1 | 0: data polling on bit 7, 1: toggle check on bit 2 |
| poll_limit | input | CNT_W | Maximum number of polls before a timeout |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted by the bus side |
| rd_addr | output | ADDR_W | Read request address |
| rsp_valid | input | 1 | Read data strobe for the outstanding request |
| rsp_data | input | DQ_W | Byte returned by the flash |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 pass, 01 fail, 10 timeout; held until the next `done` |
| err_flag | output | 1 | Sticky failure/timeout indicator |

## Verification
The assertions assume that the bus side keeps its own promises. `rsp_valid` only arrives for a request that was accepted, and it arrives at most once per request. `start` is a pulse whose fields are valid in the cycle it is high. The bench meets these assumptions with a flash model that answers each accepted request exactly once, after a random delay of zero to two cycles. The same model deasserts `rd_ready` at random to create back-pressure. Status bytes come from scripts that are biased toward busy, error and toggling patterns. The bench computes the expected result and the expected read count from those scripts with its own model of the decision rules.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;
  typedef enum logic [1:0] {
    RES_PASS    = 2'b00,
    RES_FAIL    = 2'b01,
    RES_TIMEOUT = 2'b10
  } result_e;

  typedef enum logic [1:0] {
    PH_FIRST = 2'd0,
    PH_POLL  = 2'd1,
    PH_RECHK = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_FAIL  = 2'd1,
    ACT_RECHK = 2'd2,
    ACT_MORE  = 2'd3
  } action_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/nor_poll_judge.sv
module nor_poll_judge
  import nor_poll_pkg::*;
#(
  parameter int DQ_W     = 8,
  parameter int POLL_BIT = 7,
  parameter int ERR_BIT  = 5,
  parameter int TOG_BIT  = 2
) (
  input  logic            tog_mode,
  input  phase_e          phase,
  input  logic [DQ_W-1:0] dq,
  input  logic            want_bit,
  input  logic            last_tog,
  output action_e         act
);
  logic poll_ok;
  logic tog_still;
  logic err_seen;

  assign poll_ok   = (dq[POLL_BIT] == want_bit);
  assign tog_still = (dq[TOG_BIT] == last_tog);
  assign err_seen  = dq[ERR_BIT];

  always_comb begin
    act = ACT_MORE;
    if (!tog_mode) begin
      if (phase == PH_RECHK)  act = poll_ok ? ACT_PASS : ACT_FAIL;
      else if (poll_ok)       act = ACT_PASS;
      else if (err_seen)      act = ACT_RECHK;
      else                    act = ACT_MORE;
    end else begin
      if (phase == PH_FIRST)      act = ACT_MORE;
      else if (phase == PH_RECHK) act = tog_still ? ACT_PASS : ACT_FAIL;
      else if (tog_still)         act = ACT_PASS;
      else if (err_seen)          act = ACT_RECHK;
      else                        act = ACT_MORE;
    end
  end
endmodule

// File: rtl/nor_poll_budget.sv
module nor_poll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam int WIDE = CNT_W + 1;

  logic [CNT_W-1:0] used_q;
  logic [WIDE-1:0]  used_next;
  logic [WIDE-1:0]  lim_eff;

  assign used_next = {1'b0, used_q} + WIDE'(1);
  assign lim_eff   = (limit == '0) ? WIDE'(1) : {1'b0, limit};
  assign last      = (used_next >= lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     used_q <= '0;
    else if (clear) used_q <= '0;
    else if (bump)  used_q <= used_next[CNT_W-1:0];
  end
endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DQ_W     = 8,
  parameter int CNT_W    = 16,
  parameter int POLL_BIT = 7,
  parameter int ERR_BIT  = 5,
  parameter int TOG_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DQ_W-1:0]   start_data,
  input  logic              toggle_mode,
  input  logic [CNT_W-1:0]  poll_limit,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [DQ_W-1:0]   rsp_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              err_flag
);
  state_e            state_q;
  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              want_q;
  logic              mode_q;
  logic [CNT_W-1:0]  limit_q;
  logic              tog_q;
  logic              done_q;
  result_e           res_q;
  logic              err_q;

  logic    accept;
  logic    got;
  logic    last_poll;
  action_e act;

  assign accept = start && (state_q == ST_IDLE);
  assign got    = rsp_valid && (state_q == ST_WAIT);

  nor_poll_judge #(
    .DQ_W(DQ_W), .POLL_BIT(POLL_BIT), .ERR_BIT(ERR_BIT), .TOG_BIT(TOG_BIT)
  ) u_judge (
    .tog_mode (mode_q),
    .phase    (phase_q),
    .dq       (rsp_data),
    .want_bit (want_q),
    .last_tog (tog_q),
    .act      (act)
  );

  nor_poll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .bump  (got && (phase_q != PH_RECHK)),
    .limit (limit_q),
    .last  (last_poll)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_POLL;
      addr_q  <= '0;
      want_q  <= 1'b0;
      mode_q  <= 1'b0;
      limit_q <= '0;
      tog_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_PASS;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q  <= start_addr;
            want_q  <= start_data[POLL_BIT];
            mode_q  <= toggle_mode;
            limit_q <= poll_limit;
            phase_q <= toggle_mode ? PH_FIRST : PH_POLL;
            err_q   <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (got) begin
            if (mode_q && (phase_q != PH_RECHK)) tog_q <= rsp_data[TOG_BIT];
            unique case (act)
              ACT_PASS: begin
                done_q  <= 1'b1;
                res_q   <= RES_PASS;
                state_q <= ST_IDLE;
              end
              ACT_FAIL: begin
                done_q  <= 1'b1;
                res_q   <= RES_FAIL;
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
              end
              ACT_RECHK: begin
                phase_q <= PH_RECHK;
                state_q <= ST_REQ;
              end
              default: begin
                if (last_poll) begin
                  done_q  <= 1'b1;
                  res_q   <= RES_TIMEOUT;
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  phase_q <= PH_POLL;
                  state_q <= ST_REQ;
                end
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_valid = (state_q == ST_REQ);
  assign rd_addr  = addr_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign result   = res_q;
  assign err_flag = err_q;
endmodule

// File: rtl/nor_done_poller_chk.sv
module nor_done_poller_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic              done,
  input logic [1:0]        result,
  input logic              err_flag
);
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 2'b11);

  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result != 2'b00) |-> err_flag);

  p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && (result == 2'b00) |-> !err_flag);

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !err_flag);

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(rd_addr));
endmodule

bind nor_done_poller nor_done_poller_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .err_flag (err_flag)
);

// File: tb/nor_done_poller_test.sv
module nor_done_poller_test;
  localparam int ADDR_W = 21;
  localparam int DQ_W   = 8;
  localparam int CNT_W  = 16;
  localparam int SLEN   = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DQ_W-1:0]   start_data = '0;
  logic              toggle_mode = 1'b0;
  logic [CNT_W-1:0]  poll_limit = '0;
  logic              rd_valid;
  logic              rd_ready;
  logic [ADDR_W-1:0] rd_addr;
  logic              rsp_valid;
  logic [DQ_W-1:0]   rsp_data;
  logic              busy, done, err_flag;
  logic [1:0]        result;

  always #4 clk = ~clk;

  nor_done_poller uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_data(start_data), .toggle_mode(toggle_mode), .poll_limit(poll_limit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done),
    .result(result), .err_flag(err_flag)
  );

  int compared = 0;
  int mismatched = 0;

  logic [7:0]        script [SLEN];
  int                idx = 0;
  int                nreads = 0;
  bit                addr_bad = 0;
  logic [ADDR_W-1:0] exp_addr = '0;
  int                ndone = 0;
  bit                dbl_done = 0;
  logic [1:0]        got_res = 2'b11;
  logic              got_err = 1'b0;
  logic              got_busy = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Flash model: accepts requests with random stalls, answers once after 0..2 cycles.
  initial begin : flash
    bit hs = 0;
    bit pend = 0;
    int lag = 0;
    logic [ADDR_W-1:0] hs_addr = '0;
    rd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (hs) begin
        nreads++;
        if (hs_addr != exp_addr) addr_bad = 1;
        lag = int'($urandom % 3);
        pend = 1;
      end
      if (pend) begin
        if (lag == 0) begin
          rsp_valid = 1'b1;
          rsp_data = script[(idx < SLEN) ? idx : SLEN-1];
          idx++;
          pend = 0;
        end else lag--;
      end
      rd_ready = (($urandom % 3) != 0);
      hs = rst_n && rd_valid && rd_ready;
      hs_addr = rd_addr;
    end
  end

  initial begin : done_mon
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      if (done) begin
        if (prev) dbl_done = 1;
        got_res = result; got_err = err_flag; got_busy = busy;
        ndone++;
      end
      prev = done;
    end
  end

  // Reference decision model, written from the requirements.
  function automatic void model(input bit tog, input bit e7, input int lim,
                                output logic [1:0] res, output int reads);
    int i = 0;
    int polls = 0;
    int leff = (lim == 0) ? 1 : lim;
    logic [7:0] d, d2;
    logic prev;
    res = 2'b11;
    if (!tog) begin
      while (res == 2'b11) begin
        d = script[i]; i++; polls++;
        if (d[7] == e7) res = 2'b00;
        else if (d[5]) begin
          d2 = script[i]; i++;
          res = (d2[7] == e7) ? 2'b00 : 2'b01;
        end else if (polls >= leff) res = 2'b10;
      end
    end else begin
      d = script[i]; i++; polls = 1; prev = d[2];
      if (polls >= leff) res = 2'b10;
      while (res == 2'b11) begin
        d = script[i]; i++; polls++;
        if (d[2] == prev) res = 2'b00;
        else if (d[5]) begin
          d2 = script[i]; i++;
          res = (d2[2] == d[2]) ? 2'b00 : 2'b01;
        end else begin
          prev = d[2];
          if (polls >= leff) res = 2'b10;
        end
      end
    end
    reads = i;
  endfunction

  function automatic void fill(input logic [7:0] v);
    for (int k = 0; k < SLEN; k++) script[k] = v;
  endfunction

  task automatic run_op(input string tag, input logic [ADDR_W-1:0] a, input logic [7:0] dat,
                        input bit tog, input int lim, input bit interfere);
    logic [1:0] eres;
    int ereads;
    int n0;
    int cyc;
    string rq;
    model(tog, dat[7], lim, eres, ereads);
    rq = tog ? ((eres == 2'b10) ? "R8" : "R7") : ((eres == 2'b10) ? "R8" : "R5");
    @(negedge clk);
    idx = 0; nreads = 0; addr_bad = 0; dbl_done = 0; exp_addr = a;
    n0 = ndone;
    start = 1'b1; start_addr = a; start_data = dat;
    toggle_mode = tog; poll_limit = CNT_W'(lim);
    @(negedge clk);
    start = 1'b0; start_data = ~dat; toggle_mode = ~tog; poll_limit = '0;
    check("R10", {tag, " err cleared by start"}, int'(err_flag), 0);
    if (interfere) begin
      repeat (2) @(negedge clk);
      start = 1'b1; start_addr = ~a;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (ndone == n0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    check("R9", {tag, " done seen before watchdog"}, int'(ndone != n0), 1);
    check(rq, {tag, " result"}, int'(got_res), int'(eres));
    check("R4", {tag, " read count"}, nreads, ereads);
    check(interfere ? "R11" : "R2", {tag, " read address"}, int'(addr_bad), 0);
    check("R10", {tag, " err flag at done"}, int'(got_err), int'(eres != 2'b00));
    check("R9", {tag, " single-cycle done, busy low"}, int'(dbl_done || got_busy), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    bit tg;
    bit e7;
    logic p;
    int lim;
    void'($urandom(32'd4711));
    fill(8'h00);
    repeat (3) @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "rd_valid after reset", int'(rd_valid), 0);
    check("R1", "err_flag after reset", int'(err_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: immediate pass
    fill(8'h80); run_op("R3 first-read pass", 21'h1234, 8'hC5, 0, 8, 0);
    // R4: busy twice then pass
    fill(8'h80); script[0] = 8'h00; script[1] = 8'h00;
    run_op("R4 busy then pass", 21'h0AAAA, 8'h80, 0, 8, 0);
    // R5: error bit then confirming pass
    fill(8'h00); script[0] = 8'h80; script[1] = 8'hA0; script[2] = 8'h00;
    run_op("R5 recheck pass", 21'h00555, 8'h3C, 0, 8, 0);
    // R5: error bit then confirming fail
    fill(8'hA0); run_op("R5 recheck fail", 21'h1FFFF, 8'h00, 0, 8, 0);
    // R8: timeout at limit and limit zero
    fill(8'h00); run_op("R8 timeout limit 4", 21'h00010, 8'h80, 0, 4, 0);
    fill(8'h00); run_op("R8 timeout limit 0", 21'h00020, 8'h80, 0, 0, 0);
    // R6: toggle settles
    fill(8'h00); script[0] = 8'h04;
    run_op("R6 toggle pass", 21'h00777, 8'h00, 1, 8, 0);
    // R7: toggle with error then fail / pass
    fill(8'h00); script[1] = 8'h24;
    run_op("R7 toggle recheck fail", 21'h00778, 8'h00, 1, 8, 0);
    fill(8'h24); script[0] = 8'h00;
    run_op("R7 toggle recheck pass", 21'h00779, 8'h00, 1, 8, 0);
    // R11: start while busy ignored
    fill(8'h00); run_op("R11 start while busy", 21'h0F0F0, 8'h80, 0, 12, 1);

    for (int t = 0; t < 40; t++) begin
      tg = ($urandom % 2) == 1;
      e7 = ($urandom % 2) == 1;
      lim = 1 + int'($urandom % 20);
      p = 1'b0;
      for (int k = 0; k < SLEN; k++) begin
        b = 8'($urandom);
        b[5] = (($urandom % 5) == 0);
        if (!tg) b[7] = (($urandom % 4) == 0) ? e7 : ~e7;
        else begin
          b[2] = (($urandom % 4) == 0) ? p : ~p;
          p = b[2];
        end
        script[k] = b;
      end
      run_op("random", ADDR_W'($urandom), {e7, 7'($urandom)}, tg, lim, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule